// File: doc/BRIEF.md
# Quad DAC Serial Command Receiver

This block accepts write commands for a four-channel DAC over a three-wire serial link made of an active-low select (`csn`), a serial clock (`sclk`) and a data line (`sdi`). All three pins are sampled in the faster system clock domain. Each rising serial clock edge seen while the select is low pushes one bit into a shift chain. When the select returns high, the most recent frame is decoded into a channel index and a data word. These appear with a single-cycle write strobe, which the channel registers downstream consume.

A frame is a two-bit channel index followed by the data word, most significant bit first. The data width is a parameter: 16 bits gives an 18-bit frame, and 14 bits gives a 16-bit frame. Only the last frame's worth of bits before the select rises is used. A host that pads the command to whole bytes therefore still works. The far end of the shift chain drives `sdo`, so several devices can be chained on one select.

Top module: `dac_serial_frame_rx`

## Requirements
- R1: A frame is FRAME_W = DATA_W+2 bits, sent most significant first. The first two bits form the channel index, with the first bit as its high bit. The remaining DATA_W bits are the data word, high bit first. The strobe presents them on `wr_ch` and `wr_data`.
- R2: A bit is captured only on a rising `sclk` while `csn` is low. `sclk` edges while `csn` is high leave the shift chain untouched. This is visible because `sdo` holds and a later empty select cycle decodes the earlier frame.
- R3: When `csn` rises, only the last FRAME_W captured bits are decoded. A 24-bit transfer whose final 18 bits form a valid frame produces that frame.
- R4: During a strobe, `wr_sel` is one-hot with bit `wr_ch` set: index 00 sets bit 0, 01 sets bit 1, 10 sets bit 2 and 11 sets bit 3. Outside a strobe, `wr_sel` is all zero.
- R5: Each rising edge of `csn` gives exactly one `wr_en` pulse, one system clock wide. No pulse occurs otherwise.
- R6: A bit captured from `sdi` appears on `sdo` once FRAME_W+1 captures have taken place, counting its own. That is 19 captures for DATA_W=16.
- R7: With DATA_W=14, the frame is 16 bits and the `sdo` delay is 17 captures. The 14-bit word is zero-extended to OUT_W bits on `wr_data`.
- R8: A synchronous reset clears the shift chain. Afterwards `sdo` is low, and a `csn` low/high cycle with no clocks strobes channel 0 with data 0.
- R9: While reset is held, `wr_en`, `wr_sel` and `sdo` are all low. Releasing reset with `csn` high produces no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock, asynchronous to `clk` |
| csn | input | 1 | Frame select, active low, asynchronous |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Delayed serial data out for chaining |
| wr_en | output | 1 | One-cycle write strobe |
| wr_ch | output | 2 | Decoded channel index |
| wr_sel | output | 4 | One-hot channel select, valid with `wr_en` |
| wr_data | output | OUT_W | Data word, zero-extended |

## Verification
The bench sends a 24-bit byte-padded transfer. A design that decoded the first bits instead of the last would write the wrong channel, and a 16-bit-frame instance on the same pins would see a different split of the same tail. Clock pulses are sent while the select is high, followed by an empty select cycle. A design that shifted during those pulses would move `sdo` and decode a corrupted frame. After every capture, `sdo` is compared against a bench history of sent bits, which exposes an off-by-one in the chain length of either variant. Reset in the middle of a frame, and a select rising across reset release, catch residue left in the chain and spurious strobes.

// File: rtl/dac_serial_frame_rx.sv
module dac_serial_frame_rx #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk,
  input  logic             csn,
  input  logic             sdi,
  output logic             sdo,
  output logic             wr_en,
  output logic [1:0]       wr_ch,
  output logic [3:0]       wr_sel,
  output logic [OUT_W-1:0] wr_data
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CHAIN_W = FRAME_W + 1;

  logic [2:0]         sclk_q;
  logic [2:0]         csn_q;
  logic [1:0]         sdi_q;
  logic [CHAIN_W-1:0] chain;
  logic [OUT_W-1:0]   word_ext;
  logic               shift_en;
  logic               load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      csn_q  <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      csn_q  <= {csn_q[1:0], csn};
      sdi_q  <= {sdi_q[0], sdi};
    end
  end

  assign shift_en = sclk_q[1] & ~sclk_q[2] & ~csn_q[1];
  assign load_en  = csn_q[1] & ~csn_q[2];

  always_ff @(posedge clk) begin
    if (rst)
      chain <= '0;
    else if (shift_en)
      chain <= {chain[CHAIN_W-2:0], sdi_q[1]};
  end

  assign sdo = chain[CHAIN_W-1];

  always_comb begin
    word_ext = '0;
    word_ext[DATA_W-1:0] = chain[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_ch   <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= load_en;
      if (load_en) begin
        wr_ch   <= chain[FRAME_W-1 -: 2];
        wr_data <= word_ext;
      end
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_sel
    assign wr_sel[i] = wr_en && (wr_ch == 2'(i));
  end
endmodule

// File: rtl/dac_serial_frame_rx_chk.sv
module dac_serial_frame_rx_chk #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             csn,
  input logic             sdo,
  input logic             wr_en,
  input logic [1:0]       wr_ch,
  input logic [3:0]       wr_sel,
  input logic [OUT_W-1:0] wr_data
);
  logic [3:0] live;

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 4'hF) live <= live + 4'd1;
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_strobe_from_cs_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (live >= 4'd4) && $past(csn, 3) && !$past(csn, 4));

  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_sel) == (wr_en ? 1 : 0));

  assert_sel_matches_ch_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_sel[wr_ch]);

  assert_data_zero_ext_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_data >> DATA_W) == '0));

  assert_sdo_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ((live >= 4'd4) && csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> $stable(sdo));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!sdo && !wr_en));
endmodule

bind dac_serial_frame_rx dac_serial_frame_rx_chk #(
  .DATA_W(DATA_W),
  .OUT_W (OUT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .csn    (csn),
  .sdo    (sdo),
  .wr_en  (wr_en),
  .wr_ch  (wr_ch),
  .wr_sel (wr_sel),
  .wr_data(wr_data)
);

// File: tb/dac_serial_frame_rx_tb.sv
module dac_serial_frame_rx_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic sdi = 1'b0;

  logic        sdo16, en16, sdo14, en14;
  logic [1:0]  ch16, ch14;
  logic [3:0]  sel16, sel14;
  logic [15:0] dat16, dat14;

  int checks = 0;
  int fails  = 0;
  int nbits  = 0;
  logic hist [0:4095];

  always #10 clk = ~clk;

  dac_serial_frame_rx #(.DATA_W(16), .OUT_W(16)) u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo16), .wr_en(en16), .wr_ch(ch16), .wr_sel(sel16), .wr_data(dat16));

  dac_serial_frame_rx #(.DATA_W(14), .OUT_W(16)) u_dut_n14 (
    .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo14), .wr_en(en14), .wr_ch(ch14), .wr_sel(sel14), .wr_data(dat14));

  localparam int NVEC = 6;
  localparam logic [17:0] VEC [NVEC] = '{
    18'h0_1234, 18'h1_ABCD, 18'h2_FFFF, 18'h3_8001, 18'h0_0000, 18'h3_5A5A
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] last_frame(input int fw);
    logic [17:0] r = '0;
    for (int i = 0; i < fw; i++) begin
      int idx = nbits - fw + i;
      r = {r[16:0], (idx >= 0) ? hist[idx] : 1'b0};
    end
    return r;
  endfunction

  function automatic logic exp_sdo(input int delay);
    return (nbits >= delay) ? hist[nbits - delay] : 1'b0;
  endfunction

  task automatic drive_bit(input logic b);
    @(negedge clk) sdi = b;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    if (!csn) begin
      hist[nbits] = b;
      nbits++;
      chk(sdo16 == exp_sdo(19), "R6 sdo delay 16-bit", 32'(sdo16), 32'(exp_sdo(19)));
      chk(sdo14 == exp_sdo(17), "R7 sdo delay 14-bit", 32'(sdo14), 32'(exp_sdo(17)));
    end else begin
      chk(sdo16 == exp_sdo(19), "R2 sdo held with csn high", 32'(sdo16), 32'(exp_sdo(19)));
      chk(sdo14 == exp_sdo(17), "R2 sdo held with csn high 14-bit", 32'(sdo14), 32'(exp_sdo(17)));
    end
  endtask

  task automatic send(input logic [23:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) drive_bit(v[i]);
  endtask

  task automatic open_frame();
    @(negedge clk) csn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic close_frame(input logic [1:0] c16, input logic [15:0] d16,
                             input logic [1:0] c14, input logic [15:0] d14, input string tag);
    int n16 = 0, n14 = 0;
    logic [1:0] gc16 = '0, gc14 = '0;
    logic [15:0] gd16 = '0, gd14 = '0;
    logic [3:0] gs16 = '0, gs14 = '0;
    @(negedge clk) csn = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (en16) begin n16++; gc16 = ch16; gd16 = dat16; gs16 = sel16; end
      if (en14) begin n14++; gc14 = ch14; gd14 = dat14; gs14 = sel14; end
    end
    chk(n16 == 1, {tag, " R5 one strobe 16-bit"}, 32'(n16), 1);
    chk(gc16 == c16, {tag, " R1 channel 16-bit"}, 32'(gc16), 32'(c16));
    chk(gd16 == d16, {tag, " R1 data 16-bit"}, 32'(gd16), 32'(d16));
    chk(gs16 == (4'b1 << c16), {tag, " R4 select 16-bit"}, 32'(gs16), 32'(4'b1 << c16));
    chk(n14 == 1, {tag, " R5 one strobe 14-bit"}, 32'(n14), 1);
    chk(gc14 == c14, {tag, " R7 channel 14-bit"}, 32'(gc14), 32'(c14));
    chk(gd14 == d14, {tag, " R7 data 14-bit"}, 32'(gd14), 32'(d14));
    chk(gs14 == (4'b1 << c14), {tag, " R4 select 14-bit"}, 32'(gs14), 32'(4'b1 << c14));
  endtask

  task automatic close_auto(input string tag);
    logic [17:0] f18 = last_frame(18);
    logic [17:0] f16 = last_frame(16);
    close_frame(f18[17:16], f18[15:0], f16[15:14], {2'b00, f16[13:0]}, tag);
  endtask

  task automatic do_reset();
    int n = 0;
    @(negedge clk);
    rst = 1'b1; csn = 1'b1; sclk = 1'b0; sdi = 1'b0;
    repeat (3) @(negedge clk);
    chk(!en16 && !en14, "R9 no strobe in reset", 32'({en16, en14}), 0);
    chk(sel16 == 0 && sel14 == 0, "R9 select low in reset", 32'({sel16, sel14}), 0);
    chk(!sdo16 && !sdo14, "R9 sdo low in reset", 32'({sdo16, sdo14}), 0);
    rst = 1'b0;
    nbits = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (en16 || en14) n++;
    end
    chk(n == 0, "R9 no strobe after reset release", 32'(n), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();

    // R8: empty select after reset decodes a cleared chain
    open_frame();
    close_frame(2'd0, 16'h0, 2'd0, 16'h0, "R8 empty after reset");

    // table walk: R1 R4 R5 R6, and R7 on the 16-bit tail
    for (int v = 0; v < NVEC; v++) begin
      open_frame();
      send({6'b0, VEC[v]}, 18);
      close_frame(VEC[v][17:16], VEC[v][15:0], VEC[v][15:14], {2'b00, VEC[v][13:0]}, "vec");
    end

    // R3: three padded bytes, only the tail counts
    open_frame();
    send({6'b101101, 18'h2_C3A5}, 24);
    close_frame(2'd2, 16'hC3A5, 2'd3, 16'h03A5, "R3 padded 24-bit");

    // R7: two bytes; the 16-bit-frame instance decodes them whole
    open_frame();
    send(24'h00_9ABC, 16);
    close_auto("R7 two-byte transfer");

    // R2: clocks with csn high are ignored
    send(24'hFF_FFFF, 5);
    open_frame();
    close_auto("R2 clocks while deselected");

    // R8: reset in the middle of a frame
    open_frame();
    send(24'h00_01FF, 9);
    do_reset();
    chk(!sdo16 && !sdo14, "R8 sdo low after mid-frame reset", 32'({sdo16, sdo14}), 0);
    open_frame();
    close_frame(2'd0, 16'h0, 2'd0, 16'h0, "R8 chain cleared");

    // a full frame after reset, checked through the history model
    open_frame();
    send({6'b0, 18'h1_0F0F}, 18);
    close_auto("R1 after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule